// File: doc/BRIEF.md
# Two-Dimensional Strided DMA Address Generator

This block produces the address stream for one DMA transfer. A single-cycle `start` loads a set of transfer flags, a source base, a destination base, a length word and a stride word. The block then hands out beats over a valid/ready handshake. Each beat carries a source and a destination address, with a separate valid flag for each side. One cycle after the final beat is accepted, the block raises a single-cycle `done`.

There are two modes. In linear mode the transfer is one run of bytes. In 2D mode the transfer is a number of rows of equal byte count. After each row, a signed stride is added to each side's address, which lets the transfer walk a rectangular window out of a larger frame.

Each side has its own controls: an address-increment enable, a beat width of 4 or 16 bytes, an ignore flag and a stride. An optional idle gap can be placed between beats. The data path, the memory port and the descriptor fetch are built elsewhere.

Top module: `stride_agu`

## Requirements
- R1: With flag bit 1 clear (linear mode), one transfer is a single row whose byte count is `len_word[29:0]`. The row issues ceil(count/B) beats, with a minimum of one beat. B is 16 when a non-ignored side has its wide flag set, and 4 otherwise.
- R2: With flag bit 1 set (2D mode), `len_word[15:0]` is the row byte count X and `len_word[29:16]` is Y. The block issues Y+1 rows of ceil(X/B) beats each, with a minimum of one beat per row.
- R3: Each accepted beat advances an incrementing side by its own beat width. The width is 16 bytes when that side's wide flag is set, and 4 bytes when it is clear. The source side uses bits 8 (increment) and 9 (wide). The destination side uses bits 4 (increment) and 5 (wide).
- R4: While a side's increment flag is clear, that side's address does not move within a row.
- R5: After the last beat of each row except the final one, each side adds its stride as a two's-complement number. The source stride is `stride_word[15:0]` and the destination stride is `stride_word[31:16]`. The stride is added on top of that beat's increment.
- R6: Setting flag bit 11 holds `src_valid` low for the whole transfer. Setting flag bit 7 holds `dst_valid` low. The other side's addresses are still issued.
- R7: After every accepted beat except the last one, `beat_valid` stays low for exactly the number of cycles given in flag bits 25:21.
- R8: `done` is high for exactly one cycle, namely the cycle after the last beat is accepted. In that same cycle `busy` is low.
- R9: A `start` pulse while `busy` is high has no effect on the running transfer.
- R10: While `beat_valid` is high and `beat_ready` is low, `beat_valid`, `src_addr` and `dst_addr` hold their values.
- R11: After reset, `busy`, `beat_valid` and `done` are low.
- R12: `burst_len` presents flag bits 15:12 as captured at the accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load a transfer (taken only when idle) |
| xfer_info | input | 32 | Transfer flags |
| src_base | input | AW | Source start address |
| dst_base | input | AW | Destination start address |
| len_word | input | 32 | Byte count (linear) or X/Y fields (2D) |
| stride_word | input | 32 | Signed per-row strides, source low half, destination high half |
| beat_valid | output | 1 | A beat is offered |
| beat_ready | input | 1 | Consumer accepts the beat |
| src_valid | output | 1 | Source address of this beat is meaningful |
| dst_valid | output | 1 | Destination address of this beat is meaningful |
| src_addr | output | AW | Source beat address |
| dst_addr | output | AW | Destination beat address |
| burst_len | output | 4 | Captured burst length field |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions check on every cycle the properties that follow from the handshake alone:
- offers stay stable under backpressure;
- `done` is one cycle long and follows an accepted beat;
- each inter-beat gap starts with valid low when waits are configured;
- a non-incrementing side stays still in linear mode;
- an ignored side never shows valid.

Only the bench's sweeps can show that the whole address sequence is correct. That covers the number of rows and beats, the width chosen per side, the signed row strides, the exact gap length, and the fact that a `start` issued mid-transfer changes nothing. The bench compares every offered address against closed-form expected values over many flag combinations.

// File: rtl/stride_agu.sv
module stride_agu #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   xfer_info,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [31:0]   len_word,
  input  logic [31:0]   stride_word,
  output logic          beat_valid,
  input  logic          beat_ready,
  output logic          src_valid,
  output logic          dst_valid,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [3:0]    burst_len,
  output logic          busy,
  output logic          done
);
  localparam int LW = 30;

  logic [AW-1:0] s_step, d_step, s_str, d_str;
  logic          s_ign, d_ign, s_hold, two_d;
  logic [4:0]    waits_q, wait_cnt;
  logic [LW-1:0] beats_left, row_beats_m1;
  logic [13:0]   rows_left;

  wire unused_bits = ^{xfer_info[31:26], xfer_info[20:16], xfer_info[10],
                       xfer_info[6], xfer_info[3:2], xfer_info[0], len_word[31:30]};

  wire          mode_2d  = xfer_info[1];
  wire          wide_sel = (~xfer_info[11] & xfer_info[9]) | (~xfer_info[7] & xfer_info[5]);
  wire [LW-1:0] x_bytes  = mode_2d ? {14'd0, len_word[15:0]} : len_word[LW-1:0];
  wire [LW:0]   beats_n  = wide_sel ? ({1'b0, x_bytes} + 31'd15) >> 4
                                    : ({1'b0, x_bytes} + 31'd3) >> 2;
  wire [LW-1:0] beats_m1 = (beats_n == '0) ? '0 : LW'(beats_n - 31'd1);

  wire fire     = beat_valid & beat_ready;
  wire last_bt  = (beats_left == '0) & (rows_left == '0);
  wire row_end  = (beats_left == '0);

  assign beat_valid = busy & (wait_cnt == '0);
  assign src_valid  = beat_valid & ~s_ign;
  assign dst_valid  = beat_valid & ~d_ign;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0;
      src_addr <= '0; dst_addr <= '0;
      s_step <= '0; d_step <= '0; s_str <= '0; d_str <= '0;
      s_ign <= 1'b0; d_ign <= 1'b0; s_hold <= 1'b0; two_d <= 1'b0;
      waits_q <= '0; wait_cnt <= '0;
      beats_left <= '0; row_beats_m1 <= '0; rows_left <= '0;
      burst_len <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy         <= 1'b1;
          src_addr     <= src_base;
          dst_addr     <= dst_base;
          s_step       <= xfer_info[8] ? (xfer_info[9] ? AW'(16) : AW'(4)) : '0;
          d_step       <= xfer_info[4] ? (xfer_info[5] ? AW'(16) : AW'(4)) : '0;
          s_str        <= AW'(signed'(stride_word[15:0]));
          d_str        <= AW'(signed'(stride_word[31:16]));
          s_ign        <= xfer_info[11];
          d_ign        <= xfer_info[7];
          s_hold       <= ~xfer_info[8];
          two_d        <= mode_2d;
          waits_q      <= xfer_info[25:21];
          wait_cnt     <= '0;
          burst_len    <= xfer_info[15:12];
          beats_left   <= beats_m1;
          row_beats_m1 <= beats_m1;
          rows_left    <= mode_2d ? len_word[29:16] : '0;
        end
      end else if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 5'd1;
      end else if (fire) begin
        if (last_bt) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          wait_cnt <= waits_q;
          if (row_end) begin
            rows_left  <= rows_left - 14'd1;
            beats_left <= row_beats_m1;
            src_addr   <= src_addr + s_step + s_str;
            dst_addr   <= dst_addr + d_step + d_str;
          end else begin
            beats_left <= beats_left - 30'd1;
            src_addr   <= src_addr + s_step;
            dst_addr   <= dst_addr + d_step;
          end
        end
      end
    end
  end

  assert_hold_offer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(src_addr) && $stable(dst_addr)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(beat_valid && beat_ready)) ##1 !done);

  assert_gap_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last_bt && waits_q != '0) |=> !beat_valid);

  assert_fixed_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !two_d && s_hold) |=> $stable(src_addr));

  assert_ignored_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && s_ign) |-> !src_valid);

  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_n |-> (!beat_valid && !done));
endmodule

// File: tb/test_stride_agu.sv
`timescale 1ns/1ps
module test_stride_agu;
  logic        clk = 0, rst_n = 0, start = 0, beat_ready = 0;
  logic [31:0] xfer_info = 0, src_base = 0, dst_base = 0, len_word = 0, stride_word = 0;
  logic        beat_valid, src_valid, dst_valid, busy, done;
  logic [31:0] src_addr, dst_addr;
  logic [3:0]  burst_len;
  int checks = 0, errors = 0;
  bit poke = 0;

  always #2 clk = ~clk;

  stride_agu #(.AW(32)) i_stride_agu (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_info(xfer_info),
    .src_base(src_base), .dst_base(dst_base), .len_word(len_word),
    .stride_word(stride_word), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .src_valid(src_valid), .dst_valid(dst_valid), .src_addr(src_addr),
    .dst_addr(dst_addr), .burst_len(burst_len), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] ti, sb, db, lw, sw);
    bit two = ti[1];
    bit wide = (!ti[11] && ti[9]) || (!ti[7] && ti[5]);
    int x = two ? int'(lw[15:0]) : int'(lw[29:0]);
    int rows = two ? int'(lw[29:16]) + 1 : 1;
    int bpr = wide ? (x + 15) / 16 : (x + 3) / 4;
    int total, idx = 0, gap = 0, cyc = 0;
    bit fresh = 1;
    logic [31:0] si = ti[8] ? (ti[9] ? 32'd16 : 32'd4) : 32'd0;
    logic [31:0] di = ti[4] ? (ti[5] ? 32'd16 : 32'd4) : 32'd0;
    logic [31:0] ss = 32'(signed'(sw[15:0]));
    logic [31:0] ds = 32'(signed'(sw[31:16]));
    int waits = int'(ti[25:21]);
    if (bpr == 0) bpr = 1;
    total = rows * bpr;
    @(negedge clk);
    xfer_info = ti; src_base = sb; dst_base = db; len_word = lw; stride_word = sw; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R1 busy after start", busy, 1);
    chk(burst_len == ti[15:12], "R12 burst_len", burst_len, ti[15:12]);
    while (idx < total && cyc < 4000) begin
      bit stall = (cyc % 3) == 2;
      if (poke && cyc == 1) begin
        start = 1; src_base = 32'hDEAD0000; dst_base = 32'hBEEF0000; xfer_info = 32'h0000_0002;
      end else start = 0;
      if (beat_valid) begin
        int r = idx / bpr, k = idx % bpr;
        logic [31:0] es = sb + 32'(r) * (32'(bpr) * si + ss) + 32'(k) * si;
        logic [31:0] ed = db + 32'(r) * (32'(bpr) * di + ds) + 32'(k) * di;
        if (fresh) begin
          if (idx > 0) chk(gap == waits, "R7 gap length", gap, waits);
          if (!ti[11]) chk(src_addr == es, two ? "R2/R5 src addr" : "R1/R3 src addr", src_addr, es);
          if (!ti[7])  chk(dst_addr == ed, two ? "R2/R5 dst addr" : "R1/R3 dst addr", dst_addr, ed);
          if (poke)    chk(src_addr == es, "R9 start while busy", src_addr, es);
          if (!ti[8] && !two) chk(src_addr == sb, "R4 src held", src_addr, sb);
          chk(src_valid == !ti[11], "R6 src_valid", src_valid, !ti[11]);
          chk(dst_valid == !ti[7], "R6 dst_valid", dst_valid, !ti[7]);
        end else begin
          chk(src_addr == es && dst_addr == ed, "R10 stable under stall", src_addr, es);
        end
        if (!stall) begin
          beat_ready = 1; idx++; fresh = 1; gap = 0;
        end else begin
          beat_ready = 0; fresh = 0;
        end
      end else begin
        beat_ready = 0;
        gap++;
        chk(busy == 1, "R1 still busy", busy, 1);
      end
      @(negedge clk);
      cyc++;
    end
    beat_ready = 0; start = 0;
    chk(idx == total, "R1/R2 beat count", idx, total);
    chk(done == 1 && busy == 0, "R8 done after last", done, 1);
    @(negedge clk);
    chk(done == 0, "R8 done single", done, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && beat_valid == 0 && done == 0, "R11 reset state", {busy, beat_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && beat_valid == 0, "R11 idle after reset", busy, 0);
    for (int m = 0; m < 16; m++) begin
      for (int md = 0; md < 2; md++) begin
        logic [31:0] ti = 0;
        ti[4] = m[0]; ti[5] = m[1]; ti[8] = m[2]; ti[9] = m[3];
        ti[1] = md[0];
        ti[15:12] = 4'(m);
        ti[25:21] = 5'(m % 3);
        if (md == 0) run(ti, 32'h1000, 32'h8000, 32'd37, 32'h0);
        else         run(ti, 32'h2000, 32'h9000, {2'b0, 14'd2, 16'd20}, {16'hFFC0, 16'd100});
      end
    end
    run(32'h0000_0132, 32'h4000, 32'h5000, {2'b0, 14'd3, 16'd8}, {16'd64, 16'hFFF0});
    run(32'h0000_0912, 32'h4000, 32'h5000, {2'b0, 14'd1, 16'd12}, {16'd8, 16'd8});
    run(32'h0000_01B0, 32'h4000, 32'h5000, 32'd48, 32'h0);
    run(32'h0000_0A80, 32'h4000, 32'h5000, 32'd16, 32'h0);
    run(32'h0000_0112, 32'h6000, 32'h7000, {2'b0, 14'd0, 16'd16}, 32'h0);
    run(32'h0000_0110, 32'h6000, 32'h7000, 32'd0, 32'h0);
    run(32'h0080_0102, 32'h6000, 32'h7000, {2'b0, 14'd4, 16'd3}, {16'd4, 16'hFFFC});
    poke = 1;
    run(32'h0000_0110, 32'h3000, 32'h3800, 32'd24, 32'h0);
    poke = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule